// File: doc/BRIEF.md
# Competitive-Update Coherent Cache Controller

This block is the private cache controller of one processor in a snooping multiprocessor. It keeps the tags, line states, recency ranks and a small down-counter per line of a set-associative, write-back, write-allocate cache. The data array is left out: the controller decides hits, misses, fills, victim write-backs and bus messages, and the data path follows these decisions.

Coherence is update-based with an optional competitive twist. When a peer broadcasts a write, a resident copy normally absorbs it. In competitive mode every such absorbed update spends one count of the line's counter. A copy whose counter is already exhausted drops out instead and acknowledges that it no longer holds the block. Local use recharges the counter to the threshold C, so only copies that the local processor has stopped using fall out of the sharing set. The threshold sits in a loadable register. A mode input falls back to a plain update protocol, where counters are ignored. Ten event counters can be read one at a time through a select port.

Requests are handled one per cycle. All outputs are registered and appear in the cycle after the request.

Top module: `ccu_top`

## Requirements
- R1: After synchronous reset, no line is valid, all pulse outputs are low and every statistics counter reads zero.
- R2: A processor read or write that misses installs the block. If `peer_shared` is low, `mem_rd_valid` pulses with the block address. In every case the line counter is loaded with C.
- R3: In competitive mode (`proto_sel`=1), a snooped update (`snoop_is_update`=1) that hits a valid line with a nonzero counter decrements the counter, keeps the line, and gives no `snoop_ack`.
- R4: In competitive mode, a snooped update that hits a line whose counter is zero invalidates the line and pulses `snoop_ack`. Later updates to that block give no acknowledge, and a later local access to it misses.
- R5: A local read or write hit reloads the line counter to C.
- R6: A local write that is asserted with `peer_shared` pulses `bus_upd_valid` with the address. A miss with `peer_shared` high is served by a peer: no memory read, one cache-to-cache transfer counted.
- R7: The victim is the lowest-numbered invalid way. If every way is valid, it is the way least recently touched by a local access. Snoops do not change recency.
- R8: A dirty victim pulses `mem_wb_valid` with its block address in the same cycle as the fill.
- R9: A snooped update that is absorbed clears the local dirty state, so a later eviction of that line writes nothing back.
- R10: A snooped read (`snoop_is_update`=0) that hits a valid line counts an intervention. If the line is dirty, `snoop_flush` also pulses and a flush is counted.
- R11: With `proto_sel`=0, counters are ignored. Snooped updates never invalidate and never acknowledge.
- R12: When a snoop and a processor request arrive together, the snoop is served. The processor request is dropped, with no response and no count.
- R13: `stat_sel` codes: 0 reads, 1 read misses, 2 writes, 3 write misses, 4 dirty write-backs, 5 memory transactions (fills from memory plus write-backs), 6 cache-to-cache transfers received, 7 competitive invalidations, 8 interventions, 9 flushes. `stat_value` shows the selected counter one cycle after the select changes.
- R14: A pulse on `c_load` stores `c_value` as C for later fills and hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proto_sel | input | 1 | 0 plain update, 1 competitive update |
| c_load | input | 1 | Load the threshold register |
| c_value | input | CNT_W | New threshold C |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 write, 0 read |
| cpu_req_addr | input | AW | Block address of the request |
| peer_shared | input | 1 | Another cache holds the requested block |
| snoop_valid | input | 1 | Bus transaction from a peer |
| snoop_is_update | input | 1 | 1 update broadcast, 0 read |
| snoop_addr | input | AW | Block address on the bus |
| stat_sel | input | 4 | Statistics counter select |
| cpu_resp_valid | output | 1 | Request completed |
| cpu_resp_hit | output | 1 | The completed request hit |
| mem_rd_valid | output | 1 | Fill from memory |
| mem_rd_addr | output | AW | Fill address |
| mem_wb_valid | output | 1 | Dirty victim write-back |
| mem_wb_addr | output | AW | Victim address |
| bus_upd_valid | output | 1 | Local update broadcast |
| bus_upd_addr | output | AW | Broadcast address |
| snoop_ack | output | 1 | Copy dropped after an update |
| snoop_flush | output | 1 | Dirty line supplied to a snooped read |
| stat_value | output | STAT_W | Selected statistics counter |

## Verification
The counter is checked with runs of updates to one block. The drop must come exactly after C absorbed updates, and an extra update after the drop must be silent. A run that has a local hit in the middle shows whether the counter is reloaded. Write sequences with and without `peer_shared` separate broadcast from silent writes and peer supply from memory fills. Fills into one set then show the invalid-way preference, LRU order under snoop traffic and dirty versus clean victims. The same update run in plain mode must never drop the line. A colliding snoop and request, followed by a readout of all ten counters, checks the drop priority and the event accounting.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int NUM_STATS = 10;
  localparam int S_RD      = 0;
  localparam int S_RDMISS  = 1;
  localparam int S_WR      = 2;
  localparam int S_WRMISS  = 3;
  localparam int S_WB      = 4;
  localparam int S_MEM     = 5;
  localparam int S_C2C     = 6;
  localparam int S_INV     = 7;
  localparam int S_INTV    = 8;
  localparam int S_FLUSH   = 9;
endpackage

// File: rtl/ccu_lookup.sv
module ccu_lookup #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 6,
  parameter int WW    = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [WAYS-1:0][WW-1:0]    age_i,
  input  logic [TAG_W-1:0]           tag_req,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WW-1:0]              hit_way,
  output logic [WW-1:0]              victim_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_i[w] && (tag_i[w] == tag_req);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WW'(w);
  end

  // oldest way first, then the lowest invalid way takes precedence
  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_i[w] == WW'(WAYS - 1)) victim_way = WW'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_i[w]) victim_way = WW'(w);
  end
endmodule

// File: rtl/ccu_stats.sv
module ccu_stats #(
  parameter int N      = 10,
  parameter int STAT_W = 16,
  parameter int SEL_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0][1:0]   inc,
  input  logic [SEL_W-1:0]    sel,
  output logic [STAT_W-1:0]   value
);
  logic [STAT_W-1:0] cnt [N];

  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) cnt[i] <= '0;
      else     cnt[i] <= cnt[i] + STAT_W'(inc[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else begin
      value <= '0;
      for (int i = 0; i < N; i++)
        if (sel == SEL_W'(i)) value <= cnt[i];
    end
  end
endmodule

// File: rtl/ccu_top.sv
module ccu_top #(
  parameter int AW     = 8,
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int CNT_W  = 3,
  parameter int STAT_W = 16,
  parameter int C_INIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proto_sel,
  input  logic              c_load,
  input  logic [CNT_W-1:0]  c_value,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [AW-1:0]     cpu_req_addr,
  input  logic              peer_shared,
  input  logic              snoop_valid,
  input  logic              snoop_is_update,
  input  logic [AW-1:0]     snoop_addr,
  input  logic [3:0]        stat_sel,
  output logic              cpu_resp_valid,
  output logic              cpu_resp_hit,
  output logic              mem_rd_valid,
  output logic [AW-1:0]     mem_rd_addr,
  output logic              mem_wb_valid,
  output logic [AW-1:0]     mem_wb_addr,
  output logic              bus_upd_valid,
  output logic [AW-1:0]     bus_upd_addr,
  output logic              snoop_ack,
  output logic              snoop_flush,
  output logic [STAT_W-1:0] stat_value
);
  import ccu_pkg::*;

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = AW - IDX_W;
  localparam int WW    = $clog2(WAYS);

  logic [WAYS-1:0]             valid_q [SETS];
  logic [WAYS-1:0]             dirty_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
  logic [WAYS-1:0][CNT_W-1:0]  cnt_q   [SETS];
  logic [WAYS-1:0][WW-1:0]     age_q   [SETS];
  logic [CNT_W-1:0]            c_reg;

  logic            do_cpu, do_snoop;
  logic [AW-1:0]   op_addr;
  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] tag_req;
  logic [WAYS-1:0] hit_vec;
  logic            hit;
  logic [WW-1:0]   hit_way, victim_way, use_way;
  logic            victim_dirty, cnt_zero;
  logic [NUM_STATS-1:0][1:0] inc;

  assign do_snoop = snoop_valid;
  assign do_cpu   = cpu_req_valid && !snoop_valid;
  assign op_addr  = snoop_valid ? snoop_addr : cpu_req_addr;
  assign set_idx  = op_addr[IDX_W-1:0];
  assign tag_req  = op_addr[AW-1:IDX_W];

  ccu_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .WW(WW)) u_lookup (
    .valid_i    (valid_q[set_idx]),
    .tag_i      (tag_q[set_idx]),
    .age_i      (age_q[set_idx]),
    .tag_req    (tag_req),
    .hit_vec    (hit_vec),
    .hit        (hit),
    .hit_way    (hit_way),
    .victim_way (victim_way)
  );

  assign use_way      = hit ? hit_way : victim_way;
  assign victim_dirty = valid_q[set_idx][victim_way] && dirty_q[set_idx][victim_way];
  assign cnt_zero     = (cnt_q[set_idx][hit_way] == '0);

  always_comb begin
    inc = '0;
    inc[S_RD]     = {1'b0, do_cpu && !cpu_req_write};
    inc[S_RDMISS] = {1'b0, do_cpu && !cpu_req_write && !hit};
    inc[S_WR]     = {1'b0, do_cpu && cpu_req_write};
    inc[S_WRMISS] = {1'b0, do_cpu && cpu_req_write && !hit};
    inc[S_WB]     = {1'b0, do_cpu && !hit && victim_dirty};
    inc[S_MEM]    = 2'(do_cpu && !hit && victim_dirty) + 2'(do_cpu && !hit && !peer_shared);
    inc[S_C2C]    = {1'b0, do_cpu && !hit && peer_shared};
    inc[S_INV]    = {1'b0, do_snoop && hit && snoop_is_update && proto_sel && cnt_zero};
    inc[S_INTV]   = {1'b0, do_snoop && hit && !snoop_is_update};
    inc[S_FLUSH]  = {1'b0, do_snoop && hit && !snoop_is_update && dirty_q[set_idx][hit_way]};
  end

  ccu_stats #(.N(NUM_STATS), .STAT_W(STAT_W), .SEL_W(4)) u_stats (
    .clk   (clk),
    .rst   (rst),
    .inc   (inc),
    .sel   (stat_sel),
    .value (stat_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        tag_q[s]   <= '0;
        cnt_q[s]   <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WW'(w);
      end
      c_reg          <= CNT_W'(C_INIT);
      cpu_resp_valid <= 1'b0;
      cpu_resp_hit   <= 1'b0;
      mem_rd_valid   <= 1'b0;
      mem_rd_addr    <= '0;
      mem_wb_valid   <= 1'b0;
      mem_wb_addr    <= '0;
      bus_upd_valid  <= 1'b0;
      bus_upd_addr   <= '0;
      snoop_ack      <= 1'b0;
      snoop_flush    <= 1'b0;
    end else begin
      cpu_resp_valid <= 1'b0;
      mem_rd_valid   <= 1'b0;
      mem_wb_valid   <= 1'b0;
      bus_upd_valid  <= 1'b0;
      snoop_ack      <= 1'b0;
      snoop_flush    <= 1'b0;
      if (c_load) c_reg <= c_value;

      if (do_cpu) begin
        cpu_resp_valid <= 1'b1;
        cpu_resp_hit   <= hit;
        if (!hit) begin
          if (victim_dirty) begin
            mem_wb_valid <= 1'b1;
            mem_wb_addr  <= {tag_q[set_idx][victim_way], set_idx};
          end
          if (!peer_shared) begin
            mem_rd_valid <= 1'b1;
            mem_rd_addr  <= op_addr;
          end
          valid_q[set_idx][use_way] <= 1'b1;
          tag_q[set_idx][use_way]   <= tag_req;
          dirty_q[set_idx][use_way] <= cpu_req_write;
        end else if (cpu_req_write) begin
          dirty_q[set_idx][use_way] <= 1'b1;
        end
        cnt_q[set_idx][use_way] <= c_reg;
        for (int w = 0; w < WAYS; w++) begin
          if (WW'(w) == use_way)
            age_q[set_idx][w] <= '0;
          else if (age_q[set_idx][w] < age_q[set_idx][use_way])
            age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
        end
        if (cpu_req_write && peer_shared) begin
          bus_upd_valid <= 1'b1;
          bus_upd_addr  <= op_addr;
        end
      end else if (do_snoop && hit) begin
        if (snoop_is_update) begin
          if (proto_sel && cnt_zero) begin
            valid_q[set_idx][hit_way] <= 1'b0;
            dirty_q[set_idx][hit_way] <= 1'b0;
            snoop_ack                 <= 1'b1;
          end else begin
            dirty_q[set_idx][hit_way] <= 1'b0;
            if (proto_sel)
              cnt_q[set_idx][hit_way] <= cnt_q[set_idx][hit_way] - 1'b1;
          end
        end else begin
          snoop_flush <= dirty_q[set_idx][hit_way];
        end
      end
    end
  end

  // Checks beside the logic they guard
  assert_one_way_hits_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  assert_no_ack_plain_R11: assert property (@(posedge clk) disable iff (rst)
    snoop_ack |-> $past(proto_sel && snoop_valid && snoop_is_update));
  assert_resp_needs_free_cycle_R12: assert property (@(posedge clk) disable iff (rst)
    cpu_resp_valid |-> $past(cpu_req_valid && !snoop_valid));
  assert_wb_only_on_miss_R8: assert property (@(posedge clk) disable iff (rst)
    mem_wb_valid |-> (cpu_resp_valid && !cpu_resp_hit));
  assert_upd_after_shared_write_R6: assert property (@(posedge clk) disable iff (rst)
    bus_upd_valid |-> $past(cpu_req_write && peer_shared));
  assert_ack_flush_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(snoop_ack && snoop_flush));
endmodule

// File: tb/ccu_top_bench.sv
`timescale 1ns/1ps
module ccu_top_bench;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic proto_sel = 1'b1, c_load = 1'b0;
  logic [2:0] c_value = '0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0, peer_shared = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0, snoop_addr = '0;
  logic snoop_valid = 1'b0, snoop_is_update = 1'b0;
  logic [3:0] stat_sel = '0;
  logic cpu_resp_valid, cpu_resp_hit, mem_rd_valid, mem_wb_valid, bus_upd_valid;
  logic snoop_ack, snoop_flush;
  logic [AW-1:0] mem_rd_addr, mem_wb_addr, bus_upd_addr;
  logic [15:0] stat_value;

  always #2.5 clk = ~clk;

  ccu_top u_ccu_top (
    .clk(clk), .rst(rst), .proto_sel(proto_sel), .c_load(c_load), .c_value(c_value),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .peer_shared(peer_shared), .snoop_valid(snoop_valid), .snoop_is_update(snoop_is_update),
    .snoop_addr(snoop_addr), .stat_sel(stat_sel), .cpu_resp_valid(cpu_resp_valid),
    .cpu_resp_hit(cpu_resp_hit), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_wb_valid(mem_wb_valid), .mem_wb_addr(mem_wb_addr), .bus_upd_valid(bus_upd_valid),
    .bus_upd_addr(bus_upd_addr), .snoop_ack(snoop_ack), .snoop_flush(snoop_flush),
    .stat_value(stat_value)
  );

  typedef struct packed {
    logic rv, hit, rd; logic [7:0] rda;
    logic wb; logic [7:0] wba;
    logic upd; logic [7:0] upda;
    logic ack, flush;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic exp_t mk(logic rv, logic hit, logic rd, logic [7:0] rda,
                              logic wb, logic [7:0] wba, logic upd, logic [7:0] upda,
                              logic ack, logic flush);
    mk = '{rv, hit, rd, rda, wb, wba, upd, upda, ack, flush};
  endfunction

  localparam exp_t QUIET = '0;

  // monitor: sample just after each rising edge
  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) begin
      exp_t e, a;
      string r;
      e = expq.pop_front();
      r = tagq.pop_front();
      a = mk(cpu_resp_valid, cpu_resp_valid & cpu_resp_hit,
             mem_rd_valid, mem_rd_valid ? mem_rd_addr : 8'h0,
             mem_wb_valid, mem_wb_valid ? mem_wb_addr : 8'h0,
             bus_upd_valid, bus_upd_valid ? bus_upd_addr : 8'h0,
             snoop_ack, snoop_flush);
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", r, a, e);
      end
    end
  end

  task automatic cpu_op(input logic wr, input logic [7:0] a, input logic sh,
                        input exp_t e, input string r);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; peer_shared = sh;
    expq.push_back(e); tagq.push_back(r);
    @(negedge clk);
    cpu_req_valid = 1'b0; cpu_req_write = 1'b0; peer_shared = 1'b0;
  endtask

  task automatic snoop_op(input logic up, input logic [7:0] a, input exp_t e, input string r);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_is_update = up; snoop_addr = a;
    expq.push_back(e); tagq.push_back(r);
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  task automatic both_op(input logic [7:0] ca, input logic [7:0] sa, input string r);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = ca;
    snoop_valid = 1'b1; snoop_is_update = 1'b0; snoop_addr = sa;
    expq.push_back(QUIET); tagq.push_back(r);
    @(negedge clk);
    cpu_req_valid = 1'b0; snoop_valid = 1'b0;
  endtask

  task automatic chk_stat(input logic [3:0] sel, input int v, input string r);
    @(negedge clk);
    stat_sel = sel;
    @(negedge clk);
    checks++;
    if (stat_value !== 16'(v)) begin
      fails++;
      $display("FAIL %s: stat %0d actual %0d expected %0d", r, sel, stat_value, v);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    @(negedge clk);
    checks++;
    if ({cpu_resp_valid, mem_rd_valid, mem_wb_valid, bus_upd_valid, snoop_ack, snoop_flush} !== 6'b0) begin
      fails++;
      $display("FAIL R1: actual pulses nonzero expected 0");
    end
    chk_stat(4'd0, 0, "R1 reads after reset");
    chk_stat(4'd5, 0, "R1 mem after reset");

    // R14 set C=2, competitive mode
    @(negedge clk); c_load = 1'b1; c_value = 3'd2;
    @(negedge clk); c_load = 1'b0;

    cpu_op(0, 8'h10, 0, mk(1,0,1,8'h10,0,0,0,0,0,0), "R2 read miss");
    cpu_op(0, 8'h10, 0, mk(1,1,0,0,0,0,0,0,0,0), "R2 read hit");
    snoop_op(1, 8'h10, QUIET, "R3 update 2->1");
    snoop_op(1, 8'h10, QUIET, "R3 update 1->0");
    snoop_op(1, 8'h10, mk(0,0,0,0,0,0,0,0,1,0), "R4 drop at zero");
    snoop_op(1, 8'h10, QUIET, "R4 no update after drop");
    cpu_op(0, 8'h10, 0, mk(1,0,1,8'h10,0,0,0,0,0,0), "R4 read misses after drop");
    snoop_op(1, 8'h10, QUIET, "R3 update 2->1 again");
    cpu_op(0, 8'h10, 0, mk(1,1,0,0,0,0,0,0,0,0), "R5 hit reloads");
    snoop_op(1, 8'h10, QUIET, "R5 update 2->1");
    snoop_op(1, 8'h10, QUIET, "R5 update 1->0");
    snoop_op(1, 8'h10, mk(0,0,0,0,0,0,0,0,1,0), "R5 drop after reload");

    cpu_op(1, 8'h20, 1, mk(1,0,0,0,0,0,1,8'h20,0,0), "R6 shared write miss");
    cpu_op(1, 8'h24, 0, mk(1,0,1,8'h24,0,0,0,0,0,0), "R7 invalid way first");
    cpu_op(0, 8'h28, 0, mk(1,0,1,8'h28,1,8'h20,0,0,0,0), "R8 dirty LRU victim");
    cpu_op(0, 8'h24, 0, mk(1,1,0,0,0,0,0,0,0,0), "R7 touch way");
    cpu_op(0, 8'h2C, 0, mk(1,0,1,8'h2C,0,0,0,0,0,0), "R7 LRU clean victim");
    snoop_op(0, 8'h24, mk(0,0,0,0,0,0,0,0,0,1), "R10 flush dirty");
    snoop_op(0, 8'h2C, QUIET, "R10 clean intervention");
    snoop_op(0, 8'h30, QUIET, "R10 snoop miss");

    @(negedge clk); proto_sel = 1'b0;
    for (int i = 0; i < 4; i++) snoop_op(1, 8'h2C, QUIET, "R11 plain never drops");
    cpu_op(0, 8'h2C, 0, mk(1,1,0,0,0,0,0,0,0,0), "R11 still resident");
    snoop_op(1, 8'h24, QUIET, "R9 update absorbed");
    cpu_op(0, 8'h34, 0, mk(1,0,1,8'h34,0,0,0,0,0,0), "R9 clean after update");
    both_op(8'h38, 8'h50, "R12 collision drops request");

    @(negedge clk); proto_sel = 1'b1; c_load = 1'b1; c_value = 3'd0;
    @(negedge clk); c_load = 1'b0;
    cpu_op(0, 8'h40, 0, mk(1,0,1,8'h40,0,0,0,0,0,0), "R14 fill with C=0");
    snoop_op(1, 8'h40, mk(0,0,0,0,0,0,0,0,1,0), "R14 immediate drop");

    @(negedge clk);
    chk_stat(4'd0, 10, "R13 reads");
    chk_stat(4'd1, 6,  "R13 read misses");
    chk_stat(4'd2, 2,  "R13 writes");
    chk_stat(4'd3, 2,  "R13 write misses");
    chk_stat(4'd4, 1,  "R13 writebacks");
    chk_stat(4'd5, 8,  "R13 memory transactions");
    chk_stat(4'd6, 1,  "R13 cache transfers R6");
    chk_stat(4'd7, 3,  "R13 invalidations R4");
    chk_stat(4'd8, 2,  "R13 interventions R10");
    chk_stat(4'd9, 1,  "R13 flushes");
    done = 1;
    finish_run();
  end
endmodule